// File: doc/BRIEF.md
# Multiplexed DMA Bus Master Interface

This block is the system-bus side of a peripheral that can act as both a register slave and a DMA bus master. It shares a 16-bit address/data path and an 8-bit address path between two roles. When a host accesses the peripheral, the block decodes the register access and steers the external data buffers. When the peripheral needs memory, the block runs one bus transfer. The transfer first presents the upper 24 address bits for external latching under a load strobe. It then drives the low address byte while the data moves on the shared lines.

The three-state pins are modelled as separate in, out and output-enable signals. The block also produces a bus clock at half the input frequency. A bus error during a master cycle aborts the cycle and releases the bus. The abort also raises a sticky interrupt flag, which the host clears through a register write.

Top module: `dma_bus_if`

## Requirements
- R1: `busclk` is low while `rst_n` is low. After reset it inverts on every rising edge of `clk`.
- R2: `busclk_oe` is 0 whenever `test_mode` is 1, and 1 otherwise.
- R3: In the address phase, `adld_n` is low for exactly two `clk` cycles (one bus clock). During that time `ad_out` = address[31:16], `a_out` = address[15:8], and both `ad_oe` and `a_oe` are 1.
- R4: In the data phase, `a_out` = address[7:0] and `mstb_n` is low. `xfer_write`=1 (write) sets `ad_oe`=1 with `ad_out` = write data. `xfer_write`=0 (read) sets `ad_oe`=0, and the value on `ad_in` when `dtack_n` is low is returned on `rdata` once `done` pulses.
- R5: After `xfer_start`, `bus_req` rises and stays high. While `bus_grant` is low, `adld_n` stays high.
- R6: `aen_n` is low only during the address and data phases of a master transfer.
- R7: `daten_n` is low when the block is bus master, or when `cs_n` and `ds_n` are both low. Otherwise it is high.
- R8: `datdir_n` is low when the block is bus master or `cs_n` is low. Otherwise it is high.
- R9: As a slave, `reg_addr` follows `a_in`. A read (`rw_n`=1, with `cs_n` and `ds_n` low) drives `reg_rdata` onto `ad_out` with `ad_oe`=1. A write (`rw_n`=0) gives a one-cycle `reg_wr` pulse at the start of the strobe.
- R10: If `berr_n` is low while the block is master, then on the next clock edge `a_oe`, `ad_oe` and `bus_req` are 0, `aen_n` is 1, `irq` is 1, and no `done` follows.
- R11: `irq` stays 1 until a slave write to address `CLR_ADDR` (default 8'h10) with data bit 0 = 1. A write to that address with bit 0 = 0 leaves `irq` unchanged.
- R12: `berr_n` low while the block is not master has no effect on `irq` or on the bus outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Forces the bus clock output to high impedance |
| busclk | output | 1 | Input clock divided by two |
| busclk_oe | output | 1 | Output enable of busclk |
| cs_n | input | 1 | Host chip select, active low |
| ds_n | input | 1 | Host data strobe, active low |
| rw_n | input | 1 | Host direction: 1 read, 0 write |
| a_in | input | 8 | 8-bit address lines, input side |
| a_out | output | 8 | 8-bit address lines, output side |
| a_oe | output | 1 | Output enable of the 8-bit address lines |
| ad_in | input | 16 | Shared address/data lines, input side |
| ad_out | output | 16 | Shared address/data lines, output side |
| ad_oe | output | 1 | Output enable of the shared lines |
| adld_n | output | 1 | Upper-address load strobe, active low |
| aen_n | output | 1 | External address driver enable, active low |
| daten_n | output | 1 | Data buffer enable, active low |
| datdir_n | output | 1 | Data buffer direction, low toward the system bus |
| mstb_n | output | 1 | Master data strobe, active low |
| m_rw_n | output | 1 | Master direction: 1 read, 0 write |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| dtack_n | input | 1 | Transfer acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |
| xfer_start | input | 1 | Start-transfer pulse from the DMA engine |
| xfer_write | input | 1 | 1 for a memory write, 0 for a memory read |
| xfer_addr | input | 32 | Transfer address |
| xfer_wdata | input | 16 | Write data |
| busy | output | 1 | Transfer pending or in progress |
| done | output | 1 | Transfer completed (release phase) |
| rdata | output | 16 | Data captured by a read transfer |
| reg_addr | output | 8 | Selected register address |
| reg_wdata | output | 16 | Register write data |
| reg_wr | output | 1 | Register write pulse |
| reg_rd | output | 1 | Register read active |
| reg_rdata | input | 16 | Register read data |
| irq | output | 1 | Bus-error interrupt flag |

## Verification
The assertions check the following on every cycle:
- the bus clock inverts after reset;
- the address load strobe lasts two cycles and comes only with the address drivers enabled;
- the buffer enable and direction outputs follow the host strobes;
- a bus error while master releases every bus output on the next edge and raises the flag;
- the flag holds until its clear event, and it never rises outside mastership.

Only the bench scenarios show the rest:
- the exact address slices on each phase;
- that no address appears before grant;
- the read data returned after the acknowledge;
- the one-cycle register write pulse;
- the clear-write decode, including a write whose data bit is zero.

// File: rtl/dma_bus_pkg.sv
package dma_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_REL  = 3'd4
  } mst_state_t;

  // Next master state, evaluated on a bus-clock tick.
  function automatic mst_state_t fsm_next(input mst_state_t st,
                                          input logic pend,
                                          input logic grant,
                                          input logic ack_n);
    mst_state_t nx;
    case (st)
      ST_IDLE: nx = pend ? ST_REQ : ST_IDLE;
      ST_REQ:  nx = grant ? ST_ADDR : ST_REQ;
      ST_ADDR: nx = ST_DATA;
      ST_DATA: nx = ack_n ? ST_DATA : ST_REL;
      ST_REL:  nx = ST_IDLE;
      default: nx = ST_IDLE;
    endcase
    return nx;
  endfunction

  // Master owns the external address and data lines.
  function automatic logic owns_bus(input mst_state_t st);
    return (st == ST_ADDR) || (st == ST_DATA);
  endfunction

endpackage

// File: rtl/dma_busclk_gen.sv
module dma_busclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  output logic busclk,
  output logic busclk_oe,
  output logic bus_tick
);
  logic div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= ~div_q;
  end

  assign busclk    = div_q;
  assign busclk_oe = ~test_mode;
  // Tick marks the clk edge on which busclk rises.
  assign bus_tick  = ~div_q;
endmodule

// File: rtl/dma_master_fsm.sv
module dma_master_fsm
  import dma_bus_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_tick,
  input  logic              xfer_start,
  input  logic              xfer_write,
  input  logic [DW+2*LW-1:0] xfer_addr,
  input  logic [DW-1:0]     xfer_wdata,
  input  logic              bus_grant,
  input  logic              dtack_n,
  input  logic              berr_n,
  input  logic [DW-1:0]     ad_in,
  output logic              master,
  output logic              abort,
  output logic              bus_req,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic [LW-1:0]     a_out,
  output logic              a_oe,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  output logic              adld_n,
  output logic              aen_n,
  output logic              mstb_n,
  output logic              m_rw_n
);
  localparam int AW = DW + 2*LW;

  mst_state_t        state;
  logic              pend;
  logic              wr_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rdata_q;
  logic              in_addr;
  logic              in_data;

  assign in_addr = (state == ST_ADDR);
  assign in_data = (state == ST_DATA);
  assign master  = owns_bus(state);
  assign abort   = master & ~berr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pend    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (xfer_start && (state == ST_IDLE) && !pend) begin
        pend    <= 1'b1;
        wr_q    <= xfer_write;
        addr_q  <= xfer_addr;
        wdata_q <= xfer_wdata;
      end
      if (abort) begin
        state <= ST_IDLE;
        pend  <= 1'b0;
      end else if (bus_tick) begin
        state <= fsm_next(state, pend, bus_grant, dtack_n);
        if ((state == ST_IDLE) && pend) pend <= 1'b0;
        if (in_data && !dtack_n && !wr_q) rdata_q <= ad_in;
      end
    end
  end

  assign bus_req = (state == ST_REQ) | master;
  assign busy    = (state != ST_IDLE) | pend;
  assign done    = (state == ST_REL);
  assign rdata   = rdata_q;
  assign adld_n  = ~in_addr;
  assign aen_n   = ~master;
  assign a_oe    = master;
  assign a_out   = in_addr ? addr_q[2*LW-1:LW] : addr_q[LW-1:0];
  assign ad_oe   = in_addr | (in_data & wr_q);
  assign ad_out  = in_addr ? addr_q[AW-1:2*LW] : wdata_q;
  assign mstb_n  = ~in_data;
  assign m_rw_n  = master ? ~wr_q : 1'b1;
endmodule

// File: rtl/dma_slave_decode.sv
module dma_slave_decode #(
  parameter int DW = 16,
  parameter int LW = 8,
  parameter logic [LW-1:0] CLR_ADDR = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          ds_n,
  input  logic          rw_n,
  input  logic          master,
  input  logic [LW-1:0] a_in,
  input  logic [DW-1:0] ad_in,
  output logic [LW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic          slave_drive,
  output logic          err_clr
);
  logic acc_act;
  logic acc_q;

  assign acc_act = ~cs_n & ~ds_n & ~master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_act;
  end

  assign reg_addr    = a_in;
  assign reg_wdata   = ad_in;
  assign reg_wr      = acc_act & ~acc_q & ~rw_n;
  assign reg_rd      = acc_act & rw_n;
  assign slave_drive = reg_rd;
  assign err_clr     = reg_wr & (a_in == CLR_ADDR) & ad_in[0];
endmodule

// File: rtl/dma_err_flag.sv
module dma_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end
endmodule

// File: rtl/dma_bus_if.sv
module dma_bus_if #(
  parameter int DW = 16,
  parameter int LW = 8,
  parameter logic [LW-1:0] CLR_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  output logic              busclk,
  output logic              busclk_oe,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rw_n,
  input  logic [LW-1:0]     a_in,
  output logic [LW-1:0]     a_out,
  output logic              a_oe,
  input  logic [DW-1:0]     ad_in,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  output logic              adld_n,
  output logic              aen_n,
  output logic              daten_n,
  output logic              datdir_n,
  output logic              mstb_n,
  output logic              m_rw_n,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              dtack_n,
  input  logic              berr_n,
  input  logic              xfer_start,
  input  logic              xfer_write,
  input  logic [DW+2*LW-1:0] xfer_addr,
  input  logic [DW-1:0]     xfer_wdata,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic [LW-1:0]     reg_addr,
  output logic [DW-1:0]     reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic          bus_tick;
  logic          master;
  logic          abort;
  logic          slave_drive;
  logic          err_clr;
  logic [DW-1:0] m_ad_out;
  logic          m_ad_oe;

  dma_busclk_gen u_clkgen (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .busclk(busclk), .busclk_oe(busclk_oe), .bus_tick(bus_tick)
  );

  dma_master_fsm #(.DW(DW), .LW(LW)) u_master (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
    .xfer_start(xfer_start), .xfer_write(xfer_write),
    .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
    .bus_grant(bus_grant), .dtack_n(dtack_n), .berr_n(berr_n),
    .ad_in(ad_in), .master(master), .abort(abort),
    .bus_req(bus_req), .busy(busy), .done(done), .rdata(rdata),
    .a_out(a_out), .a_oe(a_oe), .ad_out(m_ad_out), .ad_oe(m_ad_oe),
    .adld_n(adld_n), .aen_n(aen_n), .mstb_n(mstb_n), .m_rw_n(m_rw_n)
  );

  dma_slave_decode #(.DW(DW), .LW(LW), .CLR_ADDR(CLR_ADDR)) u_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rw_n(rw_n),
    .master(master), .a_in(a_in), .ad_in(ad_in),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .slave_drive(slave_drive), .err_clr(err_clr)
  );

  dma_err_flag u_err (
    .clk(clk), .rst_n(rst_n), .set_evt(abort), .clr_evt(err_clr), .flag(irq)
  );

  assign ad_out   = master ? m_ad_out : reg_rdata;
  assign ad_oe    = m_ad_oe | slave_drive;
  assign daten_n  = ~(master | (~cs_n & ~ds_n));
  assign datdir_n = ~(master | ~cs_n);
endmodule

// File: rtl/dma_bus_if_checker.sv
module dma_bus_if_checker (
  input logic clk,
  input logic rst_n,
  input logic busclk,
  input logic adld_n,
  input logic aen_n,
  input logic a_oe,
  input logic ad_oe,
  input logic bus_req,
  input logic irq,
  input logic master,
  input logic berr_n,
  input logic cs_n,
  input logic ds_n,
  input logic daten_n,
  input logic datdir_n,
  input logic err_clr
);
  assert_busclk_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> busclk != $past(busclk));

  assert_load_two_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adld_n) |=> !adld_n);

  assert_load_drivers_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adld_n |-> (a_oe && ad_oe));

  assert_aen_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adld_n |-> !aen_n);

  assert_daten_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ds_n) |-> !daten_n);

  assert_datdir_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !datdir_n);

  assert_berr_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !berr_n) |=> (!a_oe && !bus_req && aen_n && irq));

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !err_clr) |=> irq);

  assert_no_irq_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !irq) |=> !irq);
endmodule

bind dma_bus_if dma_bus_if_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busclk(busclk), .adld_n(adld_n),
  .aen_n(aen_n), .a_oe(a_oe), .ad_oe(ad_oe), .bus_req(bus_req),
  .irq(irq), .master(master), .berr_n(berr_n), .cs_n(cs_n),
  .ds_n(ds_n), .daten_n(daten_n), .datdir_n(datdir_n), .err_clr(err_clr)
);

// File: tb/dma_bus_if_bench.sv
`timescale 1ns/1ps
module dma_bus_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_mode = 1'b0;
  logic        busclk, busclk_oe;
  logic        cs_n = 1'b1, ds_n = 1'b1, rw_n = 1'b1;
  logic [7:0]  a_in = '0, a_out;
  logic        a_oe;
  logic [15:0] ad_in = '0, ad_out;
  logic        ad_oe, adld_n, aen_n, daten_n, datdir_n, mstb_n, m_rw_n;
  logic        bus_req;
  logic        bus_grant = 1'b0, dtack_n = 1'b1, berr_n = 1'b1;
  logic        xfer_start = 1'b0, xfer_write = 1'b0;
  logic [31:0] xfer_addr = '0;
  logic [15:0] xfer_wdata = '0;
  logic        busy, done;
  logic [15:0] rdata, reg_wdata, reg_rdata = '0;
  logic [7:0]  reg_addr;
  logic        reg_wr, reg_rd, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_bus_if u_dma_bus_if (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] hi_part(input logic [31:0] a); return a[31:16]; endfunction
  function automatic logic [7:0]  mid_part(input logic [31:0] a); return a[15:8]; endfunction
  function automatic logic [7:0]  lo_part(input logic [31:0] a); return a[7:0]; endfunction

  task automatic run_xfer(input logic [31:0] addr, input logic wr, input logic [15:0] wd,
                          input logic [15:0] rd, input bit with_err);
    int n;
    @(negedge clk);
    xfer_addr = addr; xfer_write = wr; xfer_wdata = wd; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    n = 0;
    while (!bus_req && n < 20) begin @(negedge clk); n++; end
    check("R5 bus_req raised", {31'd0, bus_req}, 32'd1);
    repeat (4) begin
      @(negedge clk);
      check("R5 no address before grant", {31'd0, adld_n}, 32'd1);
    end
    check("R5 request held", {31'd0, bus_req}, 32'd1);
    check("R6 aen_n idle before grant", {31'd0, aen_n}, 32'd1);
    bus_grant = 1'b1;
    n = 0;
    while (adld_n && n < 20) begin @(negedge clk); n++; end
    check("R3 upper word", {16'd0, ad_out}, {16'd0, hi_part(addr)});
    check("R3 middle byte", {24'd0, a_out}, {24'd0, mid_part(addr)});
    check("R3 drivers on", {30'd0, ad_oe, a_oe}, 32'd3);
    check("R6 aen_n in address", {31'd0, aen_n}, 32'd0);
    n = 0;
    while (!adld_n && n < 10) begin @(negedge clk); n++; end
    check("R3 load length", n, 32'd2);
    check("R4 low byte", {24'd0, a_out}, {24'd0, lo_part(addr)});
    check("R4 strobe", {31'd0, mstb_n}, 32'd0);
    check("R4 data drive", {31'd0, ad_oe}, {31'd0, wr});
    if (wr) check("R4 write data", {16'd0, ad_out}, {16'd0, wd});
    check("R7 daten as master", {31'd0, daten_n}, 32'd0);
    check("R8 datdir as master", {31'd0, datdir_n}, 32'd0);
    if (with_err) begin
      berr_n = 1'b0;
      @(negedge clk);
      berr_n = 1'b1;
      check("R10 release a_oe", {31'd0, a_oe}, 32'd0);
      check("R10 release ad_oe", {31'd0, ad_oe}, 32'd0);
      check("R10 release req", {31'd0, bus_req}, 32'd0);
      check("R10 aen_n high", {31'd0, aen_n}, 32'd1);
      check("R10 irq set", {31'd0, irq}, 32'd1);
      bus_grant = 1'b0;
      repeat (4) begin
        @(negedge clk);
        check("R10 no done", {31'd0, done}, 32'd0);
      end
      return;
    end
    repeat (3) @(negedge clk);
    check("R4 waits for ack", {31'd0, mstb_n}, 32'd0);
    ad_in = rd; dtack_n = 1'b0;
    n = 0;
    while (!done && n < 10) begin @(negedge clk); n++; end
    dtack_n = 1'b1; bus_grant = 1'b0;
    check("R4 done seen", {31'd0, done}, 32'd1);
    if (!wr) check("R4 read data", {16'd0, rdata}, {16'd0, rd});
    n = 0;
    while (busy && n < 10) begin @(negedge clk); n++; end
    check("R6 aen_n after", {31'd0, aen_n}, 32'd1);
  endtask

  task automatic slave_write(input logic [7:0] adr, input logic [15:0] dat);
    @(negedge clk);
    cs_n = 1'b0; rw_n = 1'b0; a_in = adr; ad_in = dat; ds_n = 1'b0;
    #1;
    check("R9 write pulse", {31'd0, reg_wr}, 32'd1);
    check("R9 reg addr", {24'd0, reg_addr}, {24'd0, adr});
    @(negedge clk);
    check("R9 pulse one cycle", {31'd0, reg_wr}, 32'd0);
    cs_n = 1'b1; ds_n = 1'b1; rw_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int seed;
    logic b0;
    seed = $urandom(32'h5eed);
    #12;
    check("R1 busclk in reset", {31'd0, busclk}, 32'd0);
    check("R10 irq in reset", {31'd0, irq}, 32'd0);
    check("R5 req in reset", {31'd0, bus_req}, 32'd0);
    check("R7 daten in reset", {31'd0, daten_n}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); b0 = busclk;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      b0 = ~b0;
      check("R1 busclk toggles", {31'd0, busclk}, {31'd0, b0});
    end
    check("R2 oe normal", {31'd0, busclk_oe}, 32'd1);
    test_mode = 1'b1; #1;
    check("R2 oe in test", {31'd0, busclk_oe}, 32'd0);
    test_mode = 1'b0;

    // R12: error while idle is ignored
    @(negedge clk); berr_n = 1'b0;
    repeat (3) @(negedge clk);
    berr_n = 1'b1;
    check("R12 irq unaffected", {31'd0, irq}, 32'd0);
    check("R12 bus idle", {30'd0, a_oe, bus_req}, 32'd0);

    run_xfer(32'hFFFF_FFFF, 1'b1, 16'hA5A5, 16'h0, 0);
    run_xfer(32'h0000_0000, 1'b0, 16'h0, 16'h1234, 0);
    for (int k = 0; k < 6; k++)
      run_xfer($urandom, 1'($urandom), 16'($urandom), 16'($urandom), 0);

    // Slave side
    @(negedge clk);
    reg_rdata = 16'hBEEF; a_in = 8'h22; rw_n = 1'b1; cs_n = 1'b0; ds_n = 1'b1; #1;
    check("R7 daten cs only", {31'd0, daten_n}, 32'd1);
    check("R8 datdir cs only", {31'd0, datdir_n}, 32'd0);
    check("R9 no drive without ds", {31'd0, ad_oe}, 32'd0);
    @(negedge clk); ds_n = 1'b0; #1;
    check("R7 daten cs and ds", {31'd0, daten_n}, 32'd0);
    check("R9 read drive", {31'd0, ad_oe}, 32'd1);
    check("R9 read data", {16'd0, ad_out}, 32'h0000_BEEF);
    check("R9 reg_rd", {31'd0, reg_rd}, 32'd1);
    @(negedge clk); cs_n = 1'b1; ds_n = 1'b1; #1;
    check("R8 datdir idle", {31'd0, datdir_n}, 32'd1);

    run_xfer(32'h1357_9BDF, 1'b1, 16'h5555, 16'h0, 1);
    slave_write(8'h10, 16'h0000);
    check("R11 bit0 zero keeps irq", {31'd0, irq}, 32'd1);
    slave_write(8'h11, 16'h0001);
    check("R11 other addr keeps irq", {31'd0, irq}, 32'd1);
    slave_write(8'h10, 16'h0001);
    check("R11 clear", {31'd0, irq}, 32'd0);
    run_xfer(32'h2468_ACE0, 1'b0, 16'h0, 16'hC0DE, 0);
    check("R11 stays clear", {31'd0, irq}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule